// File: doc/BRIEF.md
# Sample Buffer Group Manager

This block manages the write side of a circular analog sample store. The store holds 512 groups of 64 cells per channel. Each tick of the group-advance input moves the write pointer to the next group. The lane output toggles on every advance, so one 64-cell transfer lane records while the other hands off its contents.

A trigger freezes a window of eight consecutive groups. The window ends at the group being written, less a small programmable look-back. Frozen groups stay intact while writing continues in every other group: the pointer steps over held groups, so the store never stops recording. Each accepted window is queued. The readout side walks through the queued groups one `rd_done` pulse at a time, oldest window first. A group is returned to the writable pool one cycle after its readout completes. When every window slot is taken, `busy` is raised and further triggers are dropped.

The group count must be a power of two, so that pointer arithmetic wraps naturally.

Top module: `sample_store_mgr`

## Requirements
- R1: While `rst_n` is low, `wr_ptr` is 0, `lane` is 0, and both `busy` and `rd_valid` are 0.
- R2: On a cycle with `grp_adv` high, `wr_ptr` moves to the next group, wrapping from 511 to 0, when that group is not held. With `grp_adv` low, `wr_ptr` holds its value.
- R3: `lane` inverts on each cycle with `grp_adv` high and is unchanged otherwise.
- R4: An accepted trigger holds the 8 groups `E-7 .. E` (modulo 512), where `E = wr_ptr - look_back`, and `wr_ptr` is sampled in the trigger cycle.
- R5: On an advance, `wr_ptr` skips every held group and lands on the first group after the current one that is not held.
- R6: While `rd_valid` is high, `rd_addr` names the next held group to convert. Windows are served in trigger order, and groups within a window in ascending order. Each `rd_done` pulse moves to the next group.
- R7: A group's hold is removed in the cycle after its `rd_done` pulse is registered. An advance one cycle later can then land on it.
- R8: `busy` is high exactly when both window slots are occupied. A trigger while `busy` is high holds no groups and queues no reads.
- R9: `rd_done` while `rd_valid` is low has no effect.
- R10: A trigger and an `rd_done` in the same cycle are both taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_adv | input | 1 | Advance the write pointer by one group |
| trig | input | 1 | Freeze a window ending near the current group |
| look_back | input | 4 | Groups between the current group and the window end |
| rd_done | input | 1 | Conversion of `rd_addr` finished |
| wr_ptr | output | 9 | Group currently being written |
| lane | output | 1 | Transfer lane currently recording |
| busy | output | 1 | All window slots occupied |
| rd_valid | output | 1 | A held group awaits conversion |
| rd_addr | output | 9 | Held group to convert next |

## Verification
The assertions check, on every cycle, the local rules:
- pointer motion and lane toggling against `grp_adv`;
- no landing on a group that was held before the edge;
- holding of the window-end group;
- removal of a hold two cycles after its readout;
- trigger blocking while `busy`;
- inertness of a stray `rd_done`.

Only the bench scenarios can show the longer histories. These are:
- a full wrap of the store with a held window skipped in the middle;
- the exact order of read addresses across two queued windows;
- a dropped third trigger leaving no trace in the readout stream;
- a second pass through the store after every window has been released.

// File: rtl/sample_store_mgr.sv
module sample_store_mgr #(
  parameter int GROUPS = 512,
  parameter int WIN    = 8,
  parameter int SLOTS  = 2,
  parameter int LBW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       grp_adv,
  input  logic                       trig,
  input  logic [LBW-1:0]             look_back,
  input  logic                       rd_done,
  output logic [$clog2(GROUPS)-1:0]  wr_ptr,
  output logic                       lane,
  output logic                       busy,
  output logic                       rd_valid,
  output logic [$clog2(GROUPS)-1:0]  rd_addr
);
  localparam int AW   = $clog2(GROUPS);
  localparam int SW   = $clog2(SLOTS);
  localparam int CW   = $clog2(SLOTS + 1);
  localparam int IW   = $clog2(WIN);
  localparam int SRCH = SLOTS * WIN + 1;

  logic [GROUPS-1:0] held, set_mask, clr_mask;
  logic [AW-1:0]     base_q [SLOTS];
  logic [SW-1:0]     head, tail;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic              clr_pend;
  logic [AW-1:0]     clr_addr, nxt, win_end, win_start;

  function automatic logic [SW-1:0] bump(input logic [SW-1:0] v);
    return (v == SW'(SLOTS - 1)) ? '0 : v + SW'(1);
  endfunction

  wire take    = trig && !busy;
  wire pop_grp = rd_done && rd_valid;
  wire last    = pop_grp && (idx == IW'(WIN - 1));

  assign busy      = (cnt == CW'(SLOTS));
  assign rd_valid  = (cnt != '0);
  assign rd_addr   = base_q[head] + AW'(idx);
  assign win_end   = wr_ptr - AW'(look_back);
  assign win_start = win_end - AW'(WIN - 1);
  assign clr_mask  = {{(GROUPS-1){1'b0}}, clr_pend} << clr_addr;

  always_comb begin
    nxt = wr_ptr;
    for (int k = SRCH; k >= 1; k--)
      if (!held[wr_ptr + AW'(k)]) nxt = wr_ptr + AW'(k);
  end

  always_comb begin
    set_mask = '0;
    if (take)
      for (int k = 0; k < WIN; k++) set_mask[win_start + AW'(k)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      lane     <= 1'b0;
      held     <= '0;
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      idx      <= '0;
      clr_pend <= 1'b0;
      clr_addr <= '0;
      for (int i = 0; i < SLOTS; i++) base_q[i] <= '0;
    end else begin
      if (grp_adv) begin
        wr_ptr <= nxt;
        lane   <= ~lane;
      end
      held     <= (held & ~clr_mask) | set_mask;
      clr_pend <= pop_grp;
      clr_addr <= rd_addr;
      if (take) begin
        base_q[tail] <= win_start;
        tail         <= bump(tail);
      end
      if (pop_grp) begin
        if (last) begin
          idx  <= '0;
          head <= bump(head);
        end else begin
          idx <= idx + IW'(1);
        end
      end
      cnt <= cnt + CW'(take) - CW'(last);
    end
  end
endmodule

// File: rtl/sample_store_mgr_chk.sv
module sample_store_mgr_chk #(
  parameter int GROUPS = 512,
  parameter int LBW    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      grp_adv,
  input logic                      trig,
  input logic [LBW-1:0]            look_back,
  input logic                      rd_done,
  input logic [$clog2(GROUPS)-1:0] wr_ptr,
  input logic                      lane,
  input logic                      busy,
  input logic                      rd_valid,
  input logic [$clog2(GROUPS)-1:0] rd_addr,
  input logic [GROUPS-1:0]         held
);
  localparam int AW = $clog2(GROUPS);
  logic [GROUPS-1:0] held_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held_d <= '0;
    else        held_d <= held;

  assert_ptr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_adv |=> wr_ptr != $past(wr_ptr));
  assert_ptr_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_adv |=> $stable(wr_ptr));
  assert_lane_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_adv |=> lane != $past(lane));
  assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_adv |=> $stable(lane));
  assert_window_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> held[$past(wr_ptr - AW'(look_back))]);
  assert_skip_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grp_adv |=> !held_d[wr_ptr]);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_valid) ##1 !trig |=> !held[$past(rd_addr, 2)]);
  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && !rd_done) |=> busy);
  assert_busy_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_valid);
  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_valid && !trig) |=> !rd_valid);
endmodule

bind sample_store_mgr sample_store_mgr_chk #(.GROUPS(GROUPS), .LBW(LBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_adv(grp_adv), .trig(trig),
  .look_back(look_back), .rd_done(rd_done), .wr_ptr(wr_ptr), .lane(lane),
  .busy(busy), .rd_valid(rd_valid), .rd_addr(rd_addr), .held(held)
);

// File: tb/sample_store_mgr_test.sv
module sample_store_mgr_test;
  localparam int PERIOD = 10;
  localparam int G = 512, W = 8, S = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic grp_adv = 1'b0, trig = 1'b0, rd_done = 1'b0;
  logic [3:0] look_back = '0;
  logic [8:0] wr_ptr, rd_addr;
  logic lane, busy, rd_valid;

  sample_store_mgr uut (
    .clk(clk), .rst_n(rst_n), .grp_adv(grp_adv), .trig(trig),
    .look_back(look_back), .rd_done(rd_done), .wr_ptr(wr_ptr), .lane(lane),
    .busy(busy), .rd_valid(rd_valid), .rd_addr(rd_addr)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit ended = 0;
  int exp_q[$];
  int mbase[$];
  bit mheld[G];
  int mptr = 0, mcnt = 0, midx = 0, mclr = 0;
  bit mlane = 0, mpend = 0;

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected read addresses as conversions complete
  always @(negedge clk) begin
    if (rst_n && rd_done && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R6", int'(rd_addr), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(rd_addr == 9'(e), "R6", int'(rd_addr), e);
      end
    end
  end

  // driver: applies one cycle of stimulus and advances the reference model
  task automatic cyc(bit a, bit t, int lb, bit d, string tag);
    int nptr, e, s;
    bit take, pop;
    grp_adv = a; trig = t; look_back = 4'(lb); rd_done = d;
    @(posedge clk);
    nptr = mptr;
    if (a) begin
      for (int k = 1; k <= G; k++)
        if (!mheld[(mptr + k) % G]) begin nptr = (mptr + k) % G; break; end
      mlane = ~mlane;
    end
    if (mpend) mheld[mclr] = 0;
    mpend = 0;
    pop  = d && (mcnt > 0);
    take = t && (mcnt < S);
    if (pop) begin
      mpend = 1;
      mclr = (mbase[0] + midx) % G;
      midx++;
      if (midx == W) begin midx = 0; void'(mbase.pop_front()); mcnt--; end
    end
    if (take) begin
      e = (mptr - lb + G) % G;
      s = (e - (W - 1) + G) % G;
      for (int k = 0; k < W; k++) begin
        mheld[(s + k) % G] = 1;
        exp_q.push_back((s + k) % G);
      end
      mbase.push_back(s);
      mcnt++;
    end
    mptr = nptr;
    #2;
    chk(wr_ptr == 9'(mptr), tag, int'(wr_ptr), mptr);
    chk(lane == mlane, "R3", int'(lane), int'(mlane));
    chk(busy == (mcnt == S), "R8", int'(busy), int'(mcnt == S));
    chk(rd_valid == (mcnt > 0), "R6", int'(rd_valid), int'(mcnt > 0));
  endtask

  initial begin
    #(PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(wr_ptr == 0, "R1", int'(wr_ptr), 0);
    chk(lane == 0, "R1", int'(lane), 0);
    chk(busy == 0, "R1", int'(busy), 0);
    chk(rd_valid == 0, "R1", int'(rd_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 1, "R9");
    chk(rd_valid == 0, "R9", int'(rd_valid), 0);
    while (mptr != 20) cyc(1, 0, 0, 0, "R2");

    cyc(0, 1, 0, 0, "R4");
    chk(rd_addr == 13, "R4", int'(rd_addr), 13);

    // full wrap past the held window 13..20
    while (mptr != 12) cyc(1, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R5");
    chk(wr_ptr == 21, "R5", int'(wr_ptr), 21);

    while (mptr != 40) cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 3, 0, "R4");
    chk(busy == 1, "R8", int'(busy), 1);
    while (mptr != 50) cyc(1, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, "R8");
    chk(busy == 1, "R8", int'(busy), 1);

    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, "R6");
    chk(busy == 0, "R8", int'(busy), 0);
    chk(rd_addr == 30, "R4", int'(rd_addr), 30);

    while (mptr != 60) cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 0, 1, "R10");
    chk(busy == 1, "R10", int'(busy), 1);
    for (int i = 0; i < 15; i++) cyc(0, 0, 0, 1, "R6");
    chk(rd_valid == 0, "R8", int'(rd_valid), 0);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    cyc(0, 0, 0, 0, "R7");
    for (int i = 0; i < 520; i++) cyc(1, 0, 0, 0, "R7");
    finish_up();
  end
endmodule